// File: doc/BRIEF.md
# Modular Butterfly for Forward and Inverse Number-Theoretic Transforms

This block is one radix-2 butterfly for a number-theoretic transform over the prime field of p = 2^64 - 2^32 + 1. A k-point transform array places many copies of it in parallel stages, and the same unit serves both the forward pass and the inverse pass of a large-integer multiplier. Each accepted sample pair gives two results: the modular sum and the modular difference of a processed upper operand and a processed lower operand.

The lower operand is always multiplied by its twiddle and reduced modulo p. The upper operand is multiplied by its own twiddle only when the caller marks the sample as belonging to the last inverse stage. That twiddle already includes the 1/k scaling, so the inverse transform needs no separate scaling pass afterwards. In every other stage the upper operand goes through a delay line that matches the multiplier and reduction pipeline, so both operands reach the add/subtract stage in the same cycle.

The unit is fully pipelined and accepts a new sample pair on every clock. Each result leaves a fixed 8 cycles after its input: 4 multiplier stages, 3 reduction stages and 1 add/subtract stage. All data inputs are assumed to be already reduced into [0, p).

Top module: `ntt_butterfly_unit`

## Requirements
- R1: In every stage, the lower operand used for both outputs is (in_lo * tw_lo) mod p.
- R2: When in_fin_inv = 0, the upper operand is in_up unchanged, and tw_up has no effect on either output.
- R3: When in_fin_inv = 1, the upper operand is (in_up * tw_up) mod p.
- R4: out_sum equals (U + L) mod p, where U and L are the processed upper and lower operands.
- R5: out_dif equals (U - L) mod p, and both outputs always lie in [0, p) while out_vld is high.
- R6: out_vld is high exactly 8 clock cycles after in_vld was high, and results leave in the order their inputs arrived. Back-to-back inputs give back-to-back outputs.
- R7: out_vld is 0 during reset and after it until a valid input has moved through the pipeline. Data presented while in_vld = 0 produces no output.
- R8: The boundary values 0, 1 and p-1 on any data or twiddle input give exact results. This includes the largest product, (p-1)*(p-1).
- R9: in_fin_inv is taken per sample. Changing it between consecutive valid samples affects only the sample it arrives with.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Input sample pair is valid this cycle |
| in_fin_inv | input | 1 | 1 = last inverse stage: multiply the upper operand by tw_up |
| in_up | input | 64 | Upper sample, in [0, p) |
| in_lo | input | 64 | Lower sample, in [0, p) |
| tw_up | input | 64 | Upper twiddle, with the 1/k scaling folded in; used only in the last inverse stage |
| tw_lo | input | 64 | Lower twiddle |
| out_vld | output | 1 | Results valid this cycle |
| out_sum | output | 64 | (U + L) mod p |
| out_dif | output | 64 | (U - L) mod p |

## Verification
The assertions check the following on every cycle:
- each multiplier product is exact against its operands of four cycles before;
- each reduction result equals its product modulo p and stays below p;
- the two outputs stay below p and satisfy sum + difference = 2U (mod p);
- out_vld follows in_vld at exactly eight cycles;
- the two lane pipelines stay aligned.

Only the bench's scenarios can show the following:
- the stage flag picks the right upper operand for each sample;
- the upper twiddle has no effect outside the last inverse stage;
- the corner operands 0, 1 and p-1 are handled;
- no output comes from an idle input.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
    localparam int unsigned DW      = 64;
    localparam int unsigned HW      = DW / 2;
    localparam logic [DW-1:0] MODP  = 64'hFFFF_FFFF_0000_0001;
    localparam int unsigned MUL_STG = 4;
    localparam int unsigned RED_STG = 3;
    localparam int unsigned SUM_STG = 1;
    localparam int unsigned ALIGN   = MUL_STG + RED_STG;
    localparam int unsigned LAT     = ALIGN + SUM_STG;

    typedef logic [DW-1:0]   elem_t;
    typedef logic [2*DW-1:0] wide_t;
endpackage

// File: rtl/bfly_mul.sv
// Four-stage pipelined unsigned multiplier built from half-width partial products.
module bfly_mul #(
    parameter int unsigned W = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           vld_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic           vld_o,
    output logic [2*W-1:0] prod_o
);
    localparam int unsigned H = W / 2;

    typedef struct packed {
        logic           v1;
        logic [W-1:0]   a1;
        logic [W-1:0]   b1;
        logic           v2;
        logic [W-1:0]   ll;
        logic [W-1:0]   lh;
        logic [W-1:0]   hl;
        logic [W-1:0]   hh;
        logic           v3;
        logic [W-1:0]   ll3;
        logic [W-1:0]   hh3;
        logic [W:0]     mid3;
        logic           v4;
        logic [2*W-1:0] prod;
    } mst_t;

    mst_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // stage 1: capture operands
        st_d.v1   = vld_i;
        st_d.a1   = a_i;
        st_d.b1   = b_i;
        // stage 2: four half-width partial products
        st_d.v2   = st_q.v1;
        st_d.ll   = W'(st_q.a1[H-1:0]) * W'(st_q.b1[H-1:0]);
        st_d.lh   = W'(st_q.a1[H-1:0]) * W'(st_q.b1[W-1:H]);
        st_d.hl   = W'(st_q.a1[W-1:H]) * W'(st_q.b1[H-1:0]);
        st_d.hh   = W'(st_q.a1[W-1:H]) * W'(st_q.b1[W-1:H]);
        // stage 3: merge the cross terms
        st_d.v3   = st_q.v2;
        st_d.ll3  = st_q.ll;
        st_d.hh3  = st_q.hh;
        st_d.mid3 = {1'b0, st_q.lh} + {1'b0, st_q.hl};
        // stage 4: final assembly
        st_d.v4   = st_q.v3;
        st_d.prod = {st_q.hh3, st_q.ll3} + ((2*W)'(st_q.mid3) << H);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o  = st_q.v4;
    assign prod_o = st_q.prod;

    // R1 / R3: product matches the operands presented four cycles earlier
    a_r1_mul_exact: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (prod_o == ((2*W)'($past(a_i, 4)) * (2*W)'($past(b_i, 4)))));
endmodule

// File: rtl/bfly_red.sv
// Three-stage reduction of a 128-bit product modulo 2^64 - 2^32 + 1.
module bfly_red
    import bfly_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  vld_i,
    input  wide_t x_i,
    output logic  vld_o,
    output elem_t r_o
);
    localparam logic signed [DW+2:0] P_S  = {3'b000, MODP};
    localparam logic signed [DW+2:0] P2_S = {2'b00, MODP, 1'b0};
    localparam logic [DW:0]          P_U  = {1'b0, MODP};

    typedef struct packed {
        logic                 v1;
        logic signed [DW+2:0] s1;
        logic                 v2;
        logic [DW:0]          f2;
        logic                 v3;
        elem_t                r3;
    } rst_t;

    rst_t st_d, st_q;
    logic [HW-1:0]        seg_a;
    logic [HW-1:0]        seg_b;
    elem_t                seg_lo;
    logic signed [DW+2:0] fold;

    always_comb begin
        st_d   = st_q;
        seg_a  = x_i[2*DW-1:DW+HW];
        seg_b  = x_i[DW+HW-1:DW];
        seg_lo = x_i[DW-1:0];
        // stage 1: 2^96 = -1 and 2^64 = 2^32 - 1 (mod p)
        st_d.v1 = vld_i;
        st_d.s1 = $signed({3'b000, seg_lo})
                + $signed({3'b000, seg_b, {HW{1'b0}}})
                - $signed({{(DW+3-HW){1'b0}}, seg_b})
                - $signed({{(DW+3-HW){1'b0}}, seg_a});
        // stage 2: bring into [0, 2p)
        st_d.v2 = st_q.v1;
        if (st_q.s1 < 0)          fold = st_q.s1 + P_S;
        else if (st_q.s1 >= P2_S) fold = st_q.s1 - P2_S;
        else                      fold = st_q.s1;
        st_d.f2 = fold[DW:0];
        // stage 3: final conditional subtraction
        st_d.v3 = st_q.v2;
        st_d.r3 = (st_q.f2 >= P_U) ? DW'(st_q.f2 - P_U) : st_q.f2[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.v3;
    assign r_o   = st_q.r3;

    // R5: reduced value is canonical
    a_r5_red_range: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (r_o < MODP));
    // R8: reduction is exact for every product, including (p-1)^2
    a_r8_red_exact: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (r_o == DW'($past(x_i, 3) % {{DW{1'b0}}, MODP})));
endmodule

// File: rtl/bfly_addsub.sv
// Registered modular add and subtract, each with one conditional correction.
module bfly_addsub
    import bfly_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  vld_i,
    input  elem_t u_i,
    input  elem_t l_i,
    output logic  vld_o,
    output elem_t sum_o,
    output elem_t dif_o
);
    localparam logic [DW:0] P_U = {1'b0, MODP};

    typedef struct packed {
        logic  v;
        elem_t sum;
        elem_t dif;
    } ast_t;

    ast_t        st_d, st_q;
    logic [DW:0] raw_sum;
    logic [DW:0] raw_dif;

    always_comb begin
        st_d     = st_q;
        st_d.v   = vld_i;
        raw_sum  = {1'b0, u_i} + {1'b0, l_i};
        raw_dif  = {1'b0, u_i} - {1'b0, l_i};
        st_d.sum = (raw_sum >= P_U) ? DW'(raw_sum - P_U) : raw_sum[DW-1:0];
        st_d.dif = raw_dif[DW] ? DW'(raw_dif + P_U) : raw_dif[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.v;
    assign sum_o = st_q.sum;
    assign dif_o = st_q.dif;

    // R5: both results canonical
    a_r5_out_range: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> ((sum_o < MODP) && (dif_o < MODP)));
    // R4: sum + difference equals twice the upper operand modulo p
    a_r4_sum_dif_rel: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> (((66'(sum_o) + 66'(dif_o)) % 66'(MODP))
                   == ((66'($past(u_i)) << 1) % 66'(MODP))));
endmodule

// File: rtl/ntt_butterfly_unit.sv
// Unified forward/inverse radix-2 butterfly over GF(2^64 - 2^32 + 1).
module ntt_butterfly_unit
    import bfly_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_vld,
    input  logic        in_fin_inv,
    input  logic [63:0] in_up,
    input  logic [63:0] in_lo,
    input  logic [63:0] tw_up,
    input  logic [63:0] tw_lo,
    output logic        out_vld,
    output logic [63:0] out_sum,
    output logic [63:0] out_dif
);
    localparam int unsigned NLANE = 2;   // lane 0 lower operand, lane 1 upper operand
    localparam int unsigned CW    = $clog2(LAT + 1);

    // delay line that keeps the raw upper operand and stage flag level with the lanes
    typedef struct packed {
        logic  [ALIGN-1:0] flg;
        elem_t [ALIGN-1:0] raw;
    } dly_t;

    dly_t  dl_d, dl_q;
    elem_t op_a [NLANE];
    elem_t op_b [NLANE];
    wide_t prd  [NLANE];
    logic  pv   [NLANE];
    elem_t red  [NLANE];
    logic  rv   [NLANE];
    elem_t up_sel;
    logic  as_vld;

    assign op_a[0] = in_lo;
    assign op_b[0] = tw_lo;
    assign op_a[1] = in_up;
    assign op_b[1] = tw_up;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        bfly_mul #(.W(DW)) u_mul (
            .clk    (clk),
            .rst_n  (rst_n),
            .vld_i  (in_vld),
            .a_i    (op_a[g]),
            .b_i    (op_b[g]),
            .vld_o  (pv[g]),
            .prod_o (prd[g])
        );
        bfly_red u_red (
            .clk   (clk),
            .rst_n (rst_n),
            .vld_i (pv[g]),
            .x_i   (prd[g]),
            .vld_o (rv[g]),
            .r_o   (red[g])
        );
    end

    always_comb begin
        dl_d     = dl_q;
        dl_d.flg = {dl_q.flg[ALIGN-2:0], in_fin_inv};
        dl_d.raw = {dl_q.raw[ALIGN-2:0], in_up};
        up_sel   = dl_q.flg[ALIGN-1] ? red[1] : dl_q.raw[ALIGN-1];
        as_vld   = rv[0] & rv[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dl_q <= '0;
        else        dl_q <= dl_d;
    end

    bfly_addsub u_as (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (as_vld),
        .u_i   (up_sel),
        .l_i   (red[0]),
        .vld_o (out_vld),
        .sum_o (out_sum),
        .dif_o (out_dif)
    );

    // cycles since reset, saturating, so that latency checks never look before reset
    logic [CW-1:0] since_rst_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     since_rst_q <= '0;
        else if (since_rst_q != CW'(LAT)) since_rst_q <= since_rst_q + 1'b1;
    end

    // R6: output valid follows input valid by exactly LAT (8) cycles
    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q == CW'(LAT)) |-> (out_vld == $past(in_vld, 8)));
    // R9: both lanes stay in step, so the flag is applied to its own sample
    a_r9_lane_sync: assert property (@(posedge clk) disable iff (!rst_n)
        rv[0] == rv[1]);
    // R7: nothing leaves the unit before a full pipeline of cycles since reset
    a_r7_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q < CW'(LAT)) |-> !out_vld);
endmodule

// File: tb/ntt_butterfly_unit_test.sv
`timescale 1ns/1ps
module ntt_butterfly_unit_test;
    localparam logic [63:0] P      = 64'hFFFF_FFFF_0000_0001;
    localparam int          LATCY  = 8;
    localparam int          MAXN   = 4096;
    localparam int          WDOG   = 60000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic        in_fin_inv = 1'b0;
    logic [63:0] in_up = '0, in_lo = '0, tw_up = '0, tw_lo = '0;
    logic        out_vld;
    logic [63:0] out_sum, out_dif;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int n_sent = 0;
    int n_recv = 0;
    bit done  = 1'b0;

    logic [63:0] exp_s [MAXN];
    logic [63:0] exp_d [MAXN];
    logic        exp_f [MAXN];
    int          exp_c [MAXN];

    ntt_butterfly_unit uut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_fin_inv(in_fin_inv),
        .in_up(in_up), .in_lo(in_lo), .tw_up(tw_up), .tw_lo(tw_lo),
        .out_vld(out_vld), .out_sum(out_sum), .out_dif(out_dif)
    );

    always #10 clk = ~clk;   // 50 MHz

    function automatic logic [63:0] mmul(input logic [63:0] a, input logic [63:0] b);
        logic [127:0] t;
        t = {64'h0, a} * {64'h0, b};
        return 64'(t % {64'h0, P});
    endfunction

    function automatic logic [63:0] madd(input logic [63:0] a, input logic [63:0] b);
        logic [64:0] t;
        t = {1'b0, a} + {1'b0, b};
        return 64'(t % {1'b0, P});
    endfunction

    function automatic logic [63:0] msub(input logic [63:0] a, input logic [63:0] b);
        logic [64:0] t;
        t = {1'b0, a} + {1'b0, P} - {1'b0, b};
        return 64'(t % {1'b0, P});
    endfunction

    function automatic logic [63:0] rnd_elem();
        logic [63:0] v;
        v = {$urandom(), $urandom()};
        if (($urandom() % 8) == 0) v = P - 64'(1 + ($urandom() % 4));
        else if (v >= P)           v = v - P;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic send(input logic fin, input logic [63:0] u, input logic [63:0] l,
                        input logic [63:0] wu, input logic [63:0] wl);
        logic [63:0] up_e, lo_e;
        @(negedge clk);
        in_vld = 1'b1; in_fin_inv = fin;
        in_up = u; in_lo = l; tw_up = wu; tw_lo = wl;
        lo_e = mmul(l, wl);                 // R1
        up_e = fin ? mmul(u, wu) : u;       // R3 when set, R2 otherwise
        exp_s[n_sent] = madd(up_e, lo_e);   // R4
        exp_d[n_sent] = msub(up_e, lo_e);   // R5
        exp_f[n_sent] = fin;
        exp_c[n_sent] = cyc;
        n_sent++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b0;
            in_fin_inv = $urandom() % 2;
            in_up = rnd_elem(); in_lo = rnd_elem();
            tw_up = rnd_elem(); tw_lo = rnd_elem();
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG && !done) begin
            total++;
            bad++;
            $display("FAIL R6 watchdog act=%0d exp<%0d", cyc, WDOG);
            finish_run();
        end
    end

    // output monitor: compares every result with the stored expectation
    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            if (n_recv >= n_sent) begin
                chk(1'b0, "R7 spurious out_vld", 64'(out_vld), 64'h0);
            end else begin
                chk(out_sum == exp_s[n_recv],
                    exp_f[n_recv] ? "R4 sum (R1, R3)" : "R4 sum (R1, R2)",
                    out_sum, exp_s[n_recv]);
                chk(out_dif == exp_d[n_recv],
                    exp_f[n_recv] ? "R5 dif (R1, R3)" : "R5 dif (R1, R2)",
                    out_dif, exp_d[n_recv]);
                chk((cyc - exp_c[n_recv]) == LATCY, "R6 latency",
                    64'(cyc - exp_c[n_recv]), 64'(LATCY));
                n_recv++;
            end
        end
    end

    initial begin
        logic [63:0] corner [3];
        void'($urandom(32'd20240611));
        corner[0] = 64'h0;
        corner[1] = 64'h1;
        corner[2] = P - 64'h1;

        // R7: quiet in reset, even with inputs active
        in_vld = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(out_vld == 1'b0, "R7 reset", 64'(out_vld), 64'h0);
        end
        in_vld = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(out_vld == 1'b0, "R7 after reset", 64'(out_vld), 64'h0);
        end

        // R8: every corner combination, both stage settings, back to back
        for (int f = 0; f < 2; f++)
            for (int a = 0; a < 3; a++)
                for (int b = 0; b < 3; b++)
                    for (int c = 0; c < 3; c++)
                        for (int d = 0; d < 3; d++)
                            send(f[0], corner[a], corner[b], corner[c], corner[d]);
        idle(12);

        // R2: tw_up must not matter with the flag clear (two very different twiddles)
        send(1'b0, P - 64'h5, 64'h1234, 64'h0, 64'h77);
        send(1'b0, P - 64'h5, 64'h1234, P - 64'h1, 64'h77);
        // R9: flag alternating on consecutive samples with identical data
        for (int i = 0; i < 8; i++)
            send(i[0], 64'hDEAD_BEEF_0000_1111, 64'h0123_4567_89AB_CDEF,
                 64'h0000_0001_0000_0000, 64'hFFFF_FFFF_0000_0000);
        idle(3);

        // random traffic with idle gaps; idle cycles must not create outputs (R7)
        for (int i = 0; i < 1500; i++) begin
            send($urandom() % 2, rnd_elem(), rnd_elem(), rnd_elem(), rnd_elem());
            if (($urandom() % 5) == 0) idle(1 + ($urandom() % 3));
        end

        idle(LATCY + 12);
        chk(n_recv == n_sent, "R6 output count", 64'(n_recv), 64'(n_sent));
        chk(out_vld == 1'b0, "R7 drained", 64'(out_vld), 64'h0);
        done = 1'b1;
        finish_run();
    end
endmodule